// File: doc/BRIEF.md
# Two-Bank Byte-Addressed GPIO Controller

This block gives software control over a set of general purpose pins through a small byte-wide register port. The pins are divided at a parameterised boundary index. Pins below the boundary form a core bank. Pins at or above it form a resume bank, which sits 0x20 higher in the address space and numbers its pins from zero. Each bank holds three per-pin bit vectors, packed eight pins to a byte: pin enable, pin direction and pin level.

The controller drives an output value and an output enable for every pad. Pad inputs pass through a two-flop synchronizer before they can be read. Each pin's enable comes out of reset with its own value, given by a parameter vector. A level write to a pin that is set as an input is discarded. Supported configurations are 14 pins split at 10, 14 pins split at 5, 30 pins split at 21, and 8 pins split at 2.

Top module: `gpio_two_bank`

## Requirements
- R1: Address bit 5 selects the bank: 0 is the core bank and 1 is the resume bank. Bits 3:2 select the register group: 0 is enable, 1 is direction and 2 is level. Bits 1:0 select the byte. A core pin p uses byte p/8, bit p%8. A resume pin p uses local index p-SPLIT for the same calculation.
- R2: A read strobe on cycle t places the byte on rdata_o after the clock edge that ends cycle t. In any cycle that follows a cycle without a read strobe, rdata_o is zero.
- R3: After reset, each pin's enable bit equals its bit in EN_RESET (default 14'h1C7F), every direction bit is 1 and every level bit is 0.
- R4: A direction bit of 1 makes the pin an input and 0 makes it an output. pad_oe_o[p] is 1 exactly when pin p is enabled and is an output. pad_out_o[p] carries the stored level bit.
- R5: A write to the level group leaves the stored level bit unchanged for every pin whose direction bit is 1.
- R6: For an enabled pin, a level read returns the synchronized pad input if the pin is an input, and the stored level if it is an output. A disabled pin reads 0. A pad change is not visible to a read strobe issued on the cycle right after the change, and it is visible to the strobe after that.
- R7: The following read as zero and ignore writes: addresses with bits 7:6 non-zero, addresses with bit 4 set, group 3, and any bit that maps past the pin count of its bank.
- R8: When a read strobe and a write strobe arrive in the same cycle at the same address, the read returns the contents from before the write, and the write still takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wr_i | input | 1 | Write strobe |
| rd_i | input | 1 | Read strobe |
| addr_i | input | 8 | Byte address |
| wdata_i | input | 8 | Write data |
| rdata_o | output | 8 | Registered read data |
| pad_in_i | input | NUM_PINS | Asynchronous pad inputs |
| pad_out_o | output | NUM_PINS | Pad output values |
| pad_oe_o | output | NUM_PINS | Pad output enables |

## Verification
Two functions can fall in the same clock edge. One is a read strobe together with a write strobe on the same byte. The other is a level write that arrives while some pins are inputs. The bench provokes the first with combined read-and-write operations, in both directed and random form, and expects the read to return the old model contents; a follow-up read must return the new contents. For the second, random level writes land on mixed direction settings, and a per-pin model keeps a level bit only when its pin is an output. Each such write is judged through the pad outputs and a later level read.

// File: rtl/gpio2b_pkg.sv
package gpio2b_pkg;
  typedef enum logic [1:0] {
    GRP_EN   = 2'd0,
    GRP_DIR  = 2'd1,
    GRP_LVL  = 2'd2,
    GRP_NONE = 2'd3
  } grp_e;

  localparam int BANK_SEL_BIT = 5;
  localparam int PINS_PER_BYTE = 8;
  localparam int BYTES_PER_GRP = 4;
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W = 1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] q_o
);
  logic [W-1:0] meta_q, stab_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      meta_q <= '0;
      stab_q <= '0;
    end else begin
      meta_q <= d_i;
      stab_q <= meta_q;
    end
  end

  assign q_o = stab_q;
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
  import gpio2b_pkg::*;
#(
  parameter int           N      = 8,
  parameter logic [N-1:0] EN_RST = '1
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         sel_i,
  input  logic         wr_i,
  input  logic [4:0]   rel_i,
  input  logic [7:0]   wdata_i,
  input  logic [N-1:0] pin_in_i,
  output logic [7:0]   rd_val_o,
  output logic [N-1:0] en_o,
  output logic [N-1:0] dir_o,
  output logic [N-1:0] lvl_o
);
  localparam int MAX_PINS = PINS_PER_BYTE * BYTES_PER_GRP;

  logic [N-1:0] en_q, dir_q, lvl_q;
  grp_e         grp;
  logic [1:0]   byte_sel;

  assign grp      = rel_i[4] ? GRP_NONE : grp_e'(rel_i[3:2]);
  assign byte_sel = rel_i[1:0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      en_q  <= EN_RST;
      dir_q <= '1;
      lvl_q <= '0;
    end else if (sel_i && wr_i) begin
      for (int i = 0; i < N; i++) begin
        if ((i / PINS_PER_BYTE) == int'(byte_sel)) begin
          case (grp)
            GRP_EN:  en_q[i]  <= wdata_i[i % PINS_PER_BYTE];
            GRP_DIR: dir_q[i] <= wdata_i[i % PINS_PER_BYTE];
            // level bits of input pins are read-only
            GRP_LVL: if (!dir_q[i]) lvl_q[i] <= wdata_i[i % PINS_PER_BYTE];
            default: ;
          endcase
        end
      end
    end
  end

  always_comb begin
    rd_val_o = '0;
    for (int b = 0; b < PINS_PER_BYTE; b++) begin
      int idx;
      idx = int'(byte_sel) * PINS_PER_BYTE + b;
      if (idx < N && idx < MAX_PINS) begin
        case (grp)
          GRP_EN:  rd_val_o[b] = en_q[idx];
          GRP_DIR: rd_val_o[b] = dir_q[idx];
          GRP_LVL: rd_val_o[b] = en_q[idx] & (dir_q[idx] ? pin_in_i[idx] : lvl_q[idx]);
          default: rd_val_o[b] = 1'b0;
        endcase
      end
    end
  end

  assign en_o  = en_q;
  assign dir_o = dir_q;
  assign lvl_o = lvl_q;
endmodule

// File: rtl/gpio_two_bank.sv
module gpio_two_bank
  import gpio2b_pkg::*;
#(
  parameter int                  NUM_PINS = 14,
  parameter int                  SPLIT    = 10,
  parameter logic [NUM_PINS-1:0] EN_RESET = NUM_PINS'(14'h1C7F)
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wr_i,
  input  logic                rd_i,
  input  logic [7:0]          addr_i,
  input  logic [7:0]          wdata_i,
  output logic [7:0]          rdata_o,
  input  logic [NUM_PINS-1:0] pad_in_i,
  output logic [NUM_PINS-1:0] pad_out_o,
  output logic [NUM_PINS-1:0] pad_oe_o
);
  localparam int RES_PINS = NUM_PINS - SPLIT;

  logic [NUM_PINS-1:0] pad_sync;
  logic [NUM_PINS-1:0] en_all, dir_all, lvl_all;
  logic [7:0]          core_val, res_val, rd_mux;
  logic                hi_ok, core_sel, res_sel;
  logic [7:0]          rdata_q;

  assign hi_ok    = (addr_i[7:6] == 2'b00);
  assign core_sel = hi_ok & ~addr_i[BANK_SEL_BIT];
  assign res_sel  = hi_ok &  addr_i[BANK_SEL_BIT];

  gpio_sync #(.W(NUM_PINS)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .d_i    (pad_in_i),
    .q_o    (pad_sync)
  );

  gpio_bank #(.N(SPLIT), .EN_RST(EN_RESET[SPLIT-1:0])) u_core (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .sel_i    (core_sel),
    .wr_i     (wr_i),
    .rel_i    (addr_i[4:0]),
    .wdata_i  (wdata_i),
    .pin_in_i (pad_sync[SPLIT-1:0]),
    .rd_val_o (core_val),
    .en_o     (en_all[SPLIT-1:0]),
    .dir_o    (dir_all[SPLIT-1:0]),
    .lvl_o    (lvl_all[SPLIT-1:0])
  );

  gpio_bank #(.N(RES_PINS), .EN_RST(EN_RESET[NUM_PINS-1:SPLIT])) u_res (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .sel_i    (res_sel),
    .wr_i     (wr_i),
    .rel_i    (addr_i[4:0]),
    .wdata_i  (wdata_i),
    .pin_in_i (pad_sync[NUM_PINS-1:SPLIT]),
    .rd_val_o (res_val),
    .en_o     (en_all[NUM_PINS-1:SPLIT]),
    .dir_o    (dir_all[NUM_PINS-1:SPLIT]),
    .lvl_o    (lvl_all[NUM_PINS-1:SPLIT])
  );

  assign rd_mux = core_sel ? core_val : (res_sel ? res_val : 8'h00);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) rdata_q <= '0;
    else         rdata_q <= rd_i ? rd_mux : 8'h00;
  end

  assign rdata_o   = rdata_q;
  assign pad_oe_o  = en_all & ~dir_all;
  assign pad_out_o = lvl_all;
endmodule

// File: rtl/gpio_two_bank_chk.sv
module gpio_two_bank_chk #(
  parameter int NUM_PINS = 14
) (
  input logic                clk_i,
  input logic                rst_ni,
  input logic                wr_i,
  input logic                rd_i,
  input logic [7:0]          addr_i,
  input logic [7:0]          rdata_o,
  input logic [NUM_PINS-1:0] pad_oe_o,
  input logic [NUM_PINS-1:0] pad_out_o,
  input logic [NUM_PINS-1:0] dir_all
);
  p_rdata_idle_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !rd_i |=> (rdata_o == 8'h00));

  p_unmapped_zero_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_i && (addr_i[7:6] != 2'b00)) |=> (rdata_o == 8'h00));

  p_oe_on_write_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_i |=> $stable(pad_oe_o));

  p_level_on_write_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !wr_i |=> $stable(pad_out_o));

  for (genvar p = 0; p < NUM_PINS; p++) begin : g_pin
    p_level_masked_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
      dir_all[p] |=> $stable(pad_out_o[p]));
  end
endmodule

bind gpio_two_bank gpio_two_bank_chk #(.NUM_PINS(NUM_PINS)) u_chk (.*);

// File: tb/tb_gpio_two_bank.sv
module tb_gpio_two_bank;
  localparam int N     = 14;
  localparam int SPLIT = 10;
  localparam logic [N-1:0] EN_RST = 14'h1C7F;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic wr = 1'b0, rd = 1'b0;
  logic [7:0] addr = '0, wdata = '0;
  logic [7:0] rdata;
  logic [N-1:0] pad_in = '0, pad_out, pad_oe;

  logic [N-1:0] m_en, m_dir, m_lvl;
  int checks = 0, errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  gpio_two_bank #(.NUM_PINS(N), .SPLIT(SPLIT), .EN_RESET(EN_RST)) dut (
    .clk_i(clk), .rst_ni(rst_ni), .wr_i(wr), .rd_i(rd), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .pad_in_i(pad_in),
    .pad_out_o(pad_out), .pad_oe_o(pad_oe)
  );

  function automatic int glob(input logic bank, input int loc);
    if (!bank) return (loc < SPLIT) ? loc : -1;
    return (SPLIT + loc < N) ? SPLIT + loc : -1;
  endfunction

  function automatic logic [7:0] exp_read(input logic [7:0] a);
    logic [7:0] r = '0;
    if (a[7:6] != 2'b00 || a[4] || a[3:2] == 2'd3) return 8'h00;
    for (int b = 0; b < 8; b++) begin
      int g;
      g = glob(a[5], int'(a[1:0]) * 8 + b);
      if (g >= 0) begin
        case (a[3:2])
          2'd0:    r[b] = m_en[g];
          2'd1:    r[b] = m_dir[g];
          default: r[b] = m_en[g] & (m_dir[g] ? pad_in[g] : m_lvl[g]);
        endcase
      end
    end
    return r;
  endfunction

  task automatic model_write(input logic [7:0] a, input logic [7:0] d);
    if (a[7:6] != 2'b00 || a[4] || a[3:2] == 2'd3) return;
    for (int b = 0; b < 8; b++) begin
      int g;
      g = glob(a[5], int'(a[1:0]) * 8 + b);
      if (g >= 0) begin
        case (a[3:2])
          2'd0:    m_en[g]  = d[b];
          2'd1:    m_dir[g] = d[b];
          default: if (!m_dir[g]) m_lvl[g] = d[b];
        endcase
      end
    end
  endtask

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic do_write(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    wr = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr = 1'b0;
    model_write(a, d);
  endtask

  task automatic do_read(input logic [7:0] a, input logic [7:0] exp, input string tag);
    @(negedge clk);
    rd = 1'b1; addr = a;
    @(negedge clk);
    rd = 1'b0;
    chk(tag, {24'h0, rdata}, {24'h0, exp});
  endtask

  task automatic do_rw(input logic [7:0] a, input logic [7:0] d);
    logic [7:0] exp;
    exp = exp_read(a);
    @(negedge clk);
    rd = 1'b1; wr = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    rd = 1'b0; wr = 1'b0;
    chk("R8 read-before-write", {24'h0, rdata}, {24'h0, exp});
    model_write(a, d);
  endtask

  task automatic check_pads(input string tag);
    chk({tag, " R4 pad_oe"}, 32'(pad_oe), 32'(m_en & ~m_dir));
    chk({tag, " R4 pad_out"}, 32'(pad_out), 32'(m_lvl));
  endtask

  task automatic finish_run();
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog expired actual=hung expected=done");
      finish_run();
    end
  end

  initial begin
    void'($urandom(32'd20240611));
    m_en = EN_RST; m_dir = '1; m_lvl = '0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;

    // R3 reset state
    do_read(8'h00, 8'h7F, "R3 core enable byte0");
    do_read(8'h01, 8'h00, "R3 core enable byte1");
    do_read(8'h20, 8'h07, "R3 resume enable byte0");
    do_read(8'h04, 8'hFF, "R3 core dir byte0");
    do_read(8'h05, 8'h03, "R3/R7 core dir byte1 past pin count");
    do_read(8'h24, 8'h0F, "R1/R3 resume dir byte0");
    do_read(8'h08, 8'h00, "R3 core level");
    check_pads("R3 reset");
    chk("R2 idle rdata zero", {24'h0, rdata}, 32'h0);

    // R5 level writes masked for inputs
    do_write(8'h08, 8'hFF);
    check_pads("R5 masked");
    do_write(8'h04, 8'h00);
    do_read(8'h08, 8'h00, "R5 level unchanged after masked write");
    do_write(8'h08, 8'hAA);
    do_read(8'h08, 8'h2A, "R4/R6 output level, disabled bit7 reads zero");
    check_pads("R4 outputs");

    // R1 resume bank renumbering
    do_write(8'h21, 8'hFF);
    do_write(8'h20, 8'h0F);
    do_write(8'h24, 8'h05);
    do_write(8'h28, 8'h0F);
    do_read(8'h28, 8'h0A, "R1 resume level");
    check_pads("R1 resume");

    // R7 unmapped writes ignored
    do_write(8'hC0, 8'h00);
    do_write(8'h10, 8'h00);
    do_write(8'h0C, 8'h00);
    do_write(8'h30, 8'h00);
    do_read(8'hC0, 8'h00, "R7 high address");
    do_read(8'h0C, 8'h00, "R7 group 3");
    do_read(8'h00, 8'h7F, "R7 enable untouched");
    check_pads("R7 ignored");

    // R6 synchronizer latency on resume pin 10 (input, enabled)
    @(negedge clk);
    pad_in[10] = 1'b1;
    do_read(8'h28, 8'h0A, "R6 pad change not yet visible");
    do_read(8'h28, 8'h0B, "R6 pad change visible");
    do_write(8'h20, 8'h0E);
    do_read(8'h28, 8'h0A, "R6 disabled pin reads zero");

    // R8 directed
    do_rw(8'h04, 8'hF0);
    do_read(8'h04, 8'hF0, "R8 write took effect");

    // random phase
    for (int it = 0; it < 600; it++) begin
      int op;
      logic [7:0] a;
      op = int'($urandom_range(0, 9));
      a = {2'b00, 1'($urandom_range(0, 1)), 1'b0,
           2'($urandom_range(0, 2)), 2'($urandom_range(0, 1))};
      if ($urandom_range(0, 15) == 0) a = 8'($urandom);
      if (op < 4) begin
        do_write(a, 8'($urandom));
        check_pads("R4/R5 random");
      end else if (op < 8) begin
        do_read(a, exp_read(a), "R1/R6/R7 random read");
      end else if (op == 8) begin
        @(negedge clk);
        pad_in = N'($urandom);
        repeat (3) @(negedge clk);
      end else begin
        do_rw(a, 8'($urandom));
        check_pads("R8 random");
      end
    end
    @(negedge clk);
    chk("R2 idle rdata zero end", {24'h0, rdata}, 32'h0);
    finish_run();
  end
endmodule